// File: doc/BRIEF.md
# Burst Read Target

This block sits on a synchronous bus that carries both addresses and data on one 32-bit lane. It acts as the responding side of a read burst. Every control line is active low. Each bus signal comes in as a plain input, and the block drives its outputs together with an output-enable, so no tri-state nets are used.

A transaction opens on the clock where the frame line first goes low. On that clock the lane holds the start address, and the command/byte-enable lines hold the read command. If the address falls inside the block's window, the target claims the burst. It waits through one turnaround cycle and then returns consecutive words from a computed word table, one word per completed handshake. Either side can pause the burst: the initiator through its ready line, the target through an external stall input. The burst finishes on the handshake made while the frame line is high, and the target then drops off the bus.

Top module: `burst_read_target`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `devsel_n` and `trdy_n` are high and `ad_oe` is low.
- R2: An address phase claims the burst when `frame_n` goes low from idle and `cbe_n` is 4'b0110 (memory read). The address must lie in [BASE_ADDR, BASE_ADDR + 4*WORD_COUNT). When claimed, `devsel_n` is low from the next cycle until the burst ends.
- R3: The first cycle after a claimed address phase is a turnaround: `devsel_n` is low, `ad_oe` is low and `trdy_n` is high.
- R4: From the second cycle on, `ad_oe` is high. `ad_out` carries the word for index k, {~k[15:0], k[15:0]}. Byte b (bits 8b+7:8b) is forced to zero when `cbe_n[b]` is high. The start index is (address − BASE_ADDR) >> 2.
- R5: A word is consumed only on a rising edge where `irdy_n` and `trdy_n` are both low. The index then advances by one, modulo WORD_COUNT.
- R6: During data phases, `trdy_n` equals `stall` in the same cycle: a high `stall` holds `trdy_n` high.
- R7: While `irdy_n` is high during a data phase, the index does not move, and `ad_out` keeps the same word for unchanged byte enables.
- R8: A handshake taken with `frame_n` high is the last one. On the next cycle `devsel_n` and `trdy_n` are high and `ad_oe` is low.
- R9: An address phase outside the window, or one with a command other than memory read, is ignored. `devsel_n`, `trdy_n` stay high and `ad_oe` stays low until `frame_n` and `irdy_n` are both high. After that the target decodes a new address phase again.
- R10: `trdy_n` low and `ad_oe` high occur only while `devsel_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Transaction frame from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| ad_in | input | 32 | Address/data lane as seen by the target |
| stall | input | 1 | Forces target wait states while high |
| ad_out | output | 32 | Read data driven onto the lane |
| ad_oe | output | 1 | High while the target drives the lane |
| devsel_n | output | 1 | Target claim, active low |
| trdy_n | output | 1 | Target ready, active low |

## Verification
The bench sweeps every start index of a 16-word window with burst lengths one to four. Initiator and target wait patterns rotate under each sweep, along with several byte-enable masks. Expected words are recomputed arithmetically from the index formula. The sweep covers the turnaround cycle: a design that drives data or raises ready there would fail the R3 check. It also covers the wrap from the top of the window back to index zero, and one-word bursts where the frame line is already high at the turnaround. A design that advanced on a one-sided handshake would return skipped words. One that missed the last-phase rule would keep claiming the bus after the final word. Addresses one word below and one past the window, and a non-read command, must leave the bus untouched. Each is followed by a claimed burst, which exposes a target that never releases its skip state.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_DATA = 2'd2,
        ST_SKIP = 2'd3
    } brt_state_e;

    localparam logic [3:0] CMD_MEM_READ = 4'b0110;
    localparam int unsigned LANE_W  = 32;
    localparam int unsigned BYTES_W = LANE_W / 8;

endpackage

// File: rtl/brt_decode.sv
module brt_decode #(
    parameter logic [31:0] BASE_ADDR  = 32'h0000_1000,
    parameter int unsigned WORD_COUNT = 16,
    localparam int unsigned IDX_W     = $clog2(WORD_COUNT)
) (
    input  logic [31:0]      addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    localparam logic [32:0] SPAN = 33'(WORD_COUNT) * 33'd4;

    logic [32:0] offset;

    always_comb begin
        offset = {1'b0, addr} - {1'b0, BASE_ADDR};
        hit    = !offset[32] && (offset < SPAN);
        idx    = offset[IDX_W+1:2];
    end
endmodule

// File: rtl/brt_rom.sv
module brt_rom #(
    parameter int unsigned WORD_COUNT = 16,
    localparam int unsigned IDX_W     = $clog2(WORD_COUNT)
) (
    input  logic [IDX_W-1:0] idx,
    output logic [31:0]      word
);
    logic [31:0] table_w [WORD_COUNT];

    for (genvar g = 0; g < WORD_COUNT; g++) begin : g_word
        localparam logic [15:0] KEY = 16'(g);
        assign table_w[g] = {~KEY, KEY};
    end

    assign word = table_w[idx];
endmodule

// File: rtl/brt_mask.sv
module brt_mask
    import brt_pkg::*;
(
    input  logic [LANE_W-1:0]  word_in,
    input  logic [BYTES_W-1:0] be_n,
    output logic [LANE_W-1:0]  word_out
);
    for (genvar b = 0; b < BYTES_W; b++) begin : g_byte
        assign word_out[8*b +: 8] = be_n[b] ? 8'h00 : word_in[8*b +: 8];
    end
endmodule

// File: rtl/burst_read_target.sv
module burst_read_target
    import brt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'h0000_1000,
    parameter int unsigned WORD_COUNT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic [3:0]  cbe_n,
    input  logic [31:0] ad_in,
    input  logic        stall,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        devsel_n,
    output logic        trdy_n
);
    localparam int unsigned IDX_W = $clog2(WORD_COUNT);

    typedef struct packed {
        brt_state_e       st;
        logic [IDX_W-1:0] idx;
    } regs_t;

    regs_t            r_d, r_q;
    logic             dec_hit;
    logic [IDX_W-1:0] dec_idx;
    logic [31:0]      rom_word;
    logic [31:0]      masked_word;
    logic             xfer;

    brt_decode #(
        .BASE_ADDR  (BASE_ADDR),
        .WORD_COUNT (WORD_COUNT)
    ) i_decode (
        .addr (ad_in),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    brt_rom #(
        .WORD_COUNT (WORD_COUNT)
    ) i_rom (
        .idx  (r_q.idx),
        .word (rom_word)
    );

    brt_mask i_mask (
        .word_in  (rom_word),
        .be_n     (cbe_n),
        .word_out (masked_word)
    );

    always_comb begin
        r_d  = r_q;
        xfer = (r_q.st == ST_DATA) && !irdy_n && !stall;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!frame_n) begin
                    if (dec_hit && (cbe_n == CMD_MEM_READ)) begin
                        r_d.st  = ST_TURN;
                        r_d.idx = dec_idx;
                    end else begin
                        r_d.st = ST_SKIP;
                    end
                end
            end
            ST_TURN: r_d.st = ST_DATA;
            ST_DATA: begin
                if (xfer) begin
                    r_d.idx = r_q.idx + 1'b1;
                    if (frame_n) r_d.st = ST_IDLE;
                end
            end
            ST_SKIP: begin
                if (frame_n && irdy_n) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.idx <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        devsel_n = !((r_q.st == ST_TURN) || (r_q.st == ST_DATA));
        ad_oe    = (r_q.st == ST_DATA);
        trdy_n   = !((r_q.st == ST_DATA) && !stall);
        ad_out   = ad_oe ? masked_word : 32'h0;
    end
endmodule

// File: rtl/brt_checker.sv
module brt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_n,
    input logic        irdy_n,
    input logic [3:0]  cbe_n,
    input logic        stall,
    input logic [31:0] ad_out,
    input logic        ad_oe,
    input logic        devsel_n,
    input logic        trdy_n
);
    AST_TRDY_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n); // R10

    AST_DRIVE_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !devsel_n); // R10

    AST_TURNAROUND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> (!ad_oe && trdy_n)); // R3

    AST_STALL_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> trdy_n); // R6

    AST_HOLD_ON_INIT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n) |=> (trdy_n || !$stable(cbe_n) || $stable(ad_out))); // R7

    AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && !ad_oe)); // R8
endmodule

bind burst_read_target brt_checker i_brt_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .cbe_n    (cbe_n),
    .stall    (stall),
    .ad_out   (ad_out),
    .ad_oe    (ad_oe),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n)
);

// File: tb/test_burst_read_target.sv
`timescale 1ns/1ps
module test_burst_read_target;
    localparam logic [31:0] BASE  = 32'h0000_1000;
    localparam int          WORDS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic        stall = 1'b0;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic        devsel_n;
    logic        trdy_n;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    burst_read_target #(
        .BASE_ADDR  (BASE),
        .WORD_COUNT (WORDS)
    ) i_burst_read_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .cbe_n    (cbe_n),
        .ad_in    (ad_in),
        .stall    (stall),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n)
    );

    function automatic logic [31:0] exp_word(int k, logic [3:0] be);
        logic [15:0] key;
        logic [31:0] w;
        key = 16'(k);
        w = {~key, key};
        for (int b = 0; b < 4; b++) if (be[b]) w[8*b +: 8] = 8'h00;
        return w;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic check_idle(string req);
        chk(devsel_n && trdy_n && !ad_oe, req,
            {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
    endtask

    task automatic do_burst(int start, int len, logic [3:0] be,
                            logic [7:0] imask, logic [7:0] smask);
        int done;
        int c;
        int k;
        logic ib;
        logic sb;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; stall = 1'b0;
        ad_in = 32'(BASE + 32'(start) * 4); cbe_n = 4'b0110;
        @(posedge clk);
        @(negedge clk);
        ad_in = '0; cbe_n = be; irdy_n = 1'b0;
        frame_n = (len == 1);
        #1;
        // R2 claim and R3 turnaround
        chk(!devsel_n && !ad_oe && trdy_n, "R3",
            {29'd0, devsel_n, trdy_n, ad_oe}, 32'h2);
        @(posedge clk);
        done = 0; c = 0; k = start;
        while (done < len) begin
            @(negedge clk);
            ib = imask[c % 8];
            sb = smask[c % 8];
            c++;
            if (frame_n) ib = 1'b0;
            irdy_n = ib;
            stall  = sb;
            frame_n = frame_n || ((done == len - 1) && !ib);
            #1;
            chk(!devsel_n && ad_oe, "R2", {30'd0, devsel_n, ad_oe}, 32'h1);
            chk(trdy_n == sb, "R6", {31'd0, trdy_n}, {31'd0, sb});
            if (!trdy_n)
                chk(ad_out == exp_word(k, be), ib ? "R7" : "R4", ad_out, exp_word(k, be));
            // R5 a word counts only when both ready lines are low
            if (!ib && !sb) begin
                done++;
                k = (k + 1) % WORDS;
            end
            @(posedge clk);
        end
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1; stall = 1'b0; cbe_n = 4'hF;
        #1;
        check_idle("R8");
    endtask

    task automatic do_miss(logic [31:0] addr, logic [3:0] cmd);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; stall = 1'b0;
        ad_in = addr; cbe_n = cmd;
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            irdy_n = 1'b0; cbe_n = 4'h0; ad_in = '0;
            frame_n = (i == 3);
            #1;
            check_idle("R9");
        end
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
        #1;
        check_idle("R9");
        do_burst(3, 2, 4'h0, 8'h00, 8'h00); // R9 listens again
    endtask

    initial begin
        logic [3:0] be_set [4];
        logic [7:0] im_set [4];
        logic [7:0] sm_set [4];
        be_set[0] = 4'h0; be_set[1] = 4'h5; be_set[2] = 4'hC; be_set[3] = 4'h7;
        im_set[0] = 8'h00; im_set[1] = 8'h12; im_set[2] = 8'h00; im_set[3] = 8'h49;
        sm_set[0] = 8'h00; sm_set[1] = 8'h00; sm_set[2] = 8'h25; sm_set[3] = 8'h82;

        #1;
        check_idle("R1");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_idle("R1");

        for (int s = 0; s < WORDS; s++) begin
            for (int l = 1; l <= 4; l++) begin
                int sel;
                sel = (s + l) % 4;
                do_burst(s, l, be_set[sel], im_set[(s + 2 * l) % 4], sm_set[(s / 4 + l) % 4]);
            end
        end
        do_burst(14, 6, 4'h0, 8'h24, 8'h41); // R5 wrap across the top of the window

        do_miss(BASE - 32'd4, 4'b0110);
        do_miss(BASE + 32'(WORDS) * 4, 4'b0110);
        do_miss(BASE + 32'd8, 4'b0111);

        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule